// File: doc/BRIEF.md
# Configurable Product-Term Logic Array

This block is a small sum-of-products logic fabric whose function is set by a configuration vector. Eight dedicated inputs and ten bidirectional pins supply eighteen variables. Each variable can appear in a product term in true form, in complement form, or not at all. There are forty-two product terms. Thirty-two of them are logic terms that can feed any of ten OR gates. Each OR gate result then passes through a per-output polarity stage. The other ten product terms act as output enables, one for each bidirectional pin.

Each bidirectional pin is split into three signals: an input vector that carries the level seen on the pin, an output value, and an output enable. The array always reads the pin level as a variable, whether this block or some outside source drives that pin. The evaluation path from inputs to outputs is purely combinational.

The configuration enters one bit at a time into a shadow register and becomes live only on a load pulse. Reset puts every link in the connected state. In that state every product term is inactive, every output is non-inverting and all pin drivers are off.

Top module: `pterm_logic_array`

## Requirements
- R1: After reset, every configuration bit is 1. As a result, pin_o and pin_oe are all zero for any input values.
- R2: Product term t uses configuration bits 36t to 36t+35. For variable v, bit 36t+2v is the true link and bit 36t+2v+1 is the complement link. Variables 0 to 7 are in_i[7:0] and variables 8 to 17 are pin_i[9:0]. The term is the AND of its connected literals.
- R3: A product term with no link set evaluates to 1.
- R4: A product term that has both the true link and the complement link set for any one variable evaluates to 0, whatever the input values.
- R5: Logic term t (0 to 31) is included in the sum for output o exactly when bit 1512+32o+t is 1.
- R6: Bit 1832+o selects the polarity of output o. A 1 drives the sum to pin_o[o] unchanged; a 0 drives its complement.
- R7: Product term 32+p drives pin_oe[p] directly.
- R8: The array reads pin_i as variables whatever the value of pin_oe.
- R9: While cfg_en is high, each clk edge shifts cfg_din into the shadow register, most significant bit first. After 1842 shifts, the first bit sent sits at bit 1841.
- R10: A cfg_load pulse copies the shadow register into the active configuration. Without a load, the active configuration and the array's behaviour stay unchanged, even while bits are being shifted.
- R11: When cfg_en and cfg_load are high in the same cycle, the load captures the shadow contents as they were before that cycle's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_load | input | 1 | Copy shadow register to active configuration |
| in_i | input | 8 | Dedicated inputs |
| pin_i | input | 10 | Level present on each bidirectional pin |
| pin_o | output | 10 | Value each pin drives when enabled |
| pin_oe | output | 10 | Output enable of each bidirectional pin |

## Verification
The serial shift and the load pulse can happen in the same clock edge. In that case the load must take the shadow contents from before the shift. The bench provokes this by shifting one full configuration and then a second one, with cfg_load raised on the last bit of the second. It then compares the outputs against a model evaluated on the first configuration's last bit followed by the top 1841 bits of the second. A later load on its own must then show the whole second configuration.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned NUM_IN_DEF  = 8;
  localparam int unsigned NUM_BIO_DEF = 10;
  localparam int unsigned NUM_LT_DEF  = 32;

  // A literal pair passes when every connected literal agrees with the variable.
  function automatic logic lit_pass(input logic true_link, input logic comp_link,
                                    input logic x);
    return (~true_link | x) & (~comp_link | ~x);
  endfunction

  // Polarity stage: keep = 1 passes the sum, keep = 0 inverts it.
  function automatic logic apply_pol(input logic keep, input logic sum);
    return keep ? sum : ~sum;
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_din,
  input  logic         cfg_load,
  output logic [W-1:0] shadow_q,
  output logic [W-1:0] active_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '1;
      active_q <= '1;
    end else begin
      if (cfg_en)   shadow_q <= {shadow_q[W-2:0], cfg_din};
      if (cfg_load) active_q <= shadow_q;
    end
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int unsigned NVAR  = 18,
  parameter int unsigned NTERM = 42,
  localparam int unsigned LBITS = NTERM * NVAR * 2
) (
  input  logic [LBITS-1:0] links,
  input  logic [NVAR-1:0]  vars,
  output logic [NTERM-1:0] terms
);
  logic [NVAR-1:0] pass [NTERM];

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    for (genvar v = 0; v < NVAR; v++) begin : g_var
      assign pass[t][v] = lit_pass(links[(t*NVAR+v)*2], links[(t*NVAR+v)*2+1], vars[v]);
    end
    assign terms[t] = &pass[t];
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int unsigned NLT  = 32,
  parameter int unsigned NOUT = 10
) (
  input  logic [NLT-1:0]      lterms,
  input  logic [NLT*NOUT-1:0] or_links,
  input  logic [NOUT-1:0]     pol,
  output logic [NOUT-1:0]     sum,
  output logic [NOUT-1:0]     out
);
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    assign sum[o] = |(lterms & or_links[o*NLT +: NLT]);
    assign out[o] = apply_pol(pol[o], sum[o]);
  end
endmodule

// File: rtl/pterm_logic_array.sv
module pterm_logic_array
  import pla_pkg::*;
#(
  parameter int unsigned NUM_IN  = NUM_IN_DEF,
  parameter int unsigned NUM_BIO = NUM_BIO_DEF,
  parameter int unsigned NUM_LT  = NUM_LT_DEF,
  localparam int unsigned NVAR     = NUM_IN + NUM_BIO,
  localparam int unsigned NTERM    = NUM_LT + NUM_BIO,
  localparam int unsigned AND_BITS = NTERM * NVAR * 2,
  localparam int unsigned OR_BITS  = NUM_LT * NUM_BIO,
  localparam int unsigned OR_BASE  = AND_BITS,
  localparam int unsigned POL_BASE = AND_BITS + OR_BITS,
  localparam int unsigned CFG_W    = POL_BASE + NUM_BIO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_din,
  input  logic               cfg_load,
  input  logic [NUM_IN-1:0]  in_i,
  input  logic [NUM_BIO-1:0] pin_i,
  output logic [NUM_BIO-1:0] pin_o,
  output logic [NUM_BIO-1:0] pin_oe
);
  // Named internal events, visible to the bound checker.
  logic [CFG_W-1:0]   cfg_shadow;
  logic [CFG_W-1:0]   cfg_active;
  logic [NVAR-1:0]    var_vec;
  logic [NTERM-1:0]   term_val;
  logic [NUM_BIO-1:0] or_sum;

  pla_cfg_store #(.W(CFG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .cfg_load (cfg_load),
    .shadow_q (cfg_shadow),
    .active_q (cfg_active)
  );

  // Feedback: pin levels are array variables regardless of the enables.
  assign var_vec = {pin_i, in_i};

  pla_and_plane #(.NVAR(NVAR), .NTERM(NTERM)) u_and (
    .links (cfg_active[AND_BITS-1:0]),
    .vars  (var_vec),
    .terms (term_val)
  );

  pla_or_plane #(.NLT(NUM_LT), .NOUT(NUM_BIO)) u_or (
    .lterms   (term_val[NUM_LT-1:0]),
    .or_links (cfg_active[OR_BASE +: OR_BITS]),
    .pol      (cfg_active[POL_BASE +: NUM_BIO]),
    .sum      (or_sum),
    .out      (pin_o)
  );

  assign pin_oe = term_val[NUM_LT +: NUM_BIO];
endmodule

// File: rtl/pterm_logic_array_checker.sv
module pterm_logic_array_checker #(
  parameter int unsigned NVAR  = 18,
  parameter int unsigned NTERM = 42,
  parameter int unsigned CFG_W = 1842
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_din,
  input logic             cfg_load,
  input logic [CFG_W-1:0] cfg_shadow,
  input logic [CFG_W-1:0] cfg_active,
  input logic [NTERM-1:0] term_val
);
  logic [NTERM-1:0] conflict;

  always_comb begin
    conflict = '0;
    for (int t = 0; t < NTERM; t++)
      for (int v = 0; v < NVAR; v++)
        if (cfg_active[(t*NVAR+v)*2] && cfg_active[(t*NVAR+v)*2+1]) conflict[t] = 1'b1;
  end

  // R4: a term holding both literals of one variable is never true
  p_conflict_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict & term_val) == '0);

  // R9: shift moves the serial bit into the low end
  p_shift_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_shadow == {$past(cfg_shadow[CFG_W-2:0]), $past(cfg_din)});

  // R10 / R11: load captures the pre-edge shadow contents
  p_load_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> cfg_active == $past(cfg_shadow));

  // R10: no load, no change to the live configuration
  p_hold_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_active));

  // R9: shadow holds when shifting is off
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_shadow));
endmodule

bind pterm_logic_array pterm_logic_array_checker #(
  .NVAR(NVAR), .NTERM(NTERM), .CFG_W(CFG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en),
  .cfg_din    (cfg_din),
  .cfg_load   (cfg_load),
  .cfg_shadow (cfg_shadow),
  .cfg_active (cfg_active),
  .term_val   (term_val)
);

// File: tb/test_pterm_logic_array.sv
module test_pterm_logic_array;
  localparam int W = 1842;
  localparam int OR_B = 1512;
  localparam int POL_B = 1832;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_din = 1'b0, cfg_load = 1'b0;
  logic [7:0] in_i = '0;
  logic [9:0] pin_i = '0;
  logic [9:0] pin_o, pin_oe;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pterm_logic_array i_pterm_logic_array (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_load(cfg_load), .in_i(in_i), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // Reference: returns {oe, out} from the requirement text.
  function automatic logic [19:0] model(input logic [W-1:0] c, input logic [7:0] a,
                                        input logic [9:0] b);
    logic [41:0] tv;
    logic [9:0] o, oe;
    for (int t = 0; t < 42; t++) begin
      tv[t] = 1'b1;
      for (int v = 0; v < 18; v++) begin
        logic x;
        x = (v < 8) ? a[v] : b[v-8];
        if (c[36*t+2*v] && !x) tv[t] = 1'b0;
        if (c[36*t+2*v+1] && x) tv[t] = 1'b0;
      end
    end
    for (int k = 0; k < 10; k++) begin
      logic s;
      s = 1'b0;
      for (int t = 0; t < 32; t++) if (c[OR_B+32*k+t] && tv[t]) s = 1'b1;
      o[k] = c[POL_B+k] ? s : !s;
      oe[k] = tv[32+k];
    end
    return {oe, o};
  endfunction

  function automatic logic [W-1:0] rand_cfg();
    logic [W-1:0] c;
    c = '0;
    for (int t = 0; t < 42; t++)
      for (int v = 0; v < 18; v++) begin
        int r;
        r = int'($urandom % 16);
        if (r == 0) c[36*t+2*v] = 1'b1;
        else if (r == 1) c[36*t+2*v+1] = 1'b1;
        else if (r == 2 && ($urandom % 8) == 0) begin
          c[36*t+2*v] = 1'b1;
          c[36*t+2*v+1] = 1'b1;
        end
      end
    for (int i = OR_B; i < W; i++) c[i] = 1'($urandom);
    return c;
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual oe=%h o=%h expected oe=%h o=%h", req,
               act[19:10], act[9:0], exp[19:10], exp[9:0]);
    end
  endtask

  task automatic apply(input string req, input logic [W-1:0] c,
                       input logic [7:0] a, input logic [9:0] b);
    @(negedge clk);
    in_i = a;
    pin_i = b;
    #2;
    check(req, {pin_oe, pin_o}, model(c, a, b));
  endtask

  task automatic shift_cfg(input logic [W-1:0] c, input bit load_last);
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_din = c[i];
      cfg_load = load_last && (i == 0);
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_load = 1'b0;
  endtask

  task automatic load_pulse();
    @(negedge clk);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog R9: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] ca, cb, cd;
    void'($urandom(32'd1153));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, all links intact
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_i = 8'($urandom);
      pin_i = 10'($urandom);
      #2;
      check("R1 reset outputs", {pin_oe, pin_o}, 20'h0);
    end

    // R10: shifting without load leaves behaviour unchanged
    ca = rand_cfg();
    shift_cfg(ca, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_i = 8'($urandom);
      pin_i = 10'($urandom);
      #2;
      check("R10 hold before load", {pin_oe, pin_o}, 20'h0);
    end
    load_pulse();
    for (int i = 0; i < 8; i++) apply("R9/R10 after load", ca, 8'($urandom), 10'($urandom));

    // R3/R6/R7: empty terms are true; polarity; enables
    cd = '0;
    cd[OR_B + 0] = 1'b1;
    cd[POL_B +: 10] = 10'h3FD;
    shift_cfg(cd, 1'b0);
    load_pulse();
    @(negedge clk); in_i = 8'h5A; pin_i = 10'h2C3; #2;
    check("R3/R6/R7 directed", {pin_oe, pin_o}, {10'h3FF, 10'h003});

    // R4: conflicting links on term 0 and on control term of pin 2
    cd[36*0 + 2*3] = 1'b1;  cd[36*0 + 2*3 + 1] = 1'b1;
    cd[36*34 + 2*12] = 1'b1; cd[36*34 + 2*12 + 1] = 1'b1;
    shift_cfg(cd, 1'b0);
    load_pulse();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_i = 8'($urandom); pin_i = 10'($urandom); #2;
      check("R4 conflict term", {pin_oe, pin_o}, {10'h3FB, 10'h002});
    end

    // R2/R8: term 0 follows pin_i[1] (variable 9) while pin 1 is enabled
    cd = '0;
    cd[36*0 + 2*9] = 1'b1;
    cd[OR_B + 0] = 1'b1;
    cd[POL_B +: 10] = 10'h3FF;
    shift_cfg(cd, 1'b0);
    load_pulse();
    @(negedge clk); in_i = 8'hFF; pin_i = 10'h002; #2;
    check("R2/R8 feedback high", {pin_oe, pin_o}, {10'h3FF, 10'h001});
    @(negedge clk); pin_i = 10'h3FD; #2;
    check("R2/R8 feedback low", {pin_oe, pin_o}, {10'h3FF, 10'h000});

    // R11: load in the same cycle as the final shift
    ca = rand_cfg();
    cb = rand_cfg();
    shift_cfg(ca, 1'b0);
    shift_cfg(cb, 1'b1);
    cd = {ca[0], cb[W-1:1]};
    for (int i = 0; i < 8; i++) apply("R11 load with shift", cd, 8'($urandom), 10'($urandom));
    load_pulse();
    for (int i = 0; i < 8; i++) apply("R11 later load", cb, 8'($urandom), 10'($urandom));

    // R2/R5/R6/R7/R8: random configurations and vectors
    for (int k = 0; k < 30; k++) begin
      ca = rand_cfg();
      shift_cfg(ca, 1'b0);
      load_pulse();
      for (int i = 0; i < 20; i++)
        apply("R2/R5/R6/R7/R8 random", ca, 8'($urandom), 10'($urandom));
    end

    // R1: reset again restores intact links
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); in_i = 8'hA5; pin_i = 10'h155; #2;
    check("R1 re-reset", {pin_oe, pin_o}, 20'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule